// File: doc/BRIEF.md
# Phase-Lead Bandwidth Code Search

This block searches for the control code that matches a tunable filter's corner to an unknown external network. It takes two squared-up waveforms: a reference tone and the filtered sense output. It hands the chosen code to an external converter that sets the filter's transconductance. The block makes its own decision clock from the sense waveform: every eighth rising edge of the squared sense signal is one decision point. At each decision point it samples the squared reference to learn whether the sense output leads it. A lead means the code is still too low.

Two search orders are offered, and the choice is captured when a start pulse arrives:
- **Linear search** begins at the lowest code. It steps up by one per decision while the lead persists, and freezes on the first code whose decision shows no lead.
- **Binary search** resolves one bit per decision, most significant first. It ends at the highest code that still showed a lead.

Both asynchronous waveforms are re-timed through a two-flop chain before use. The result is held, with a done flag, until the next start pulse or reset. An overflow flag reports that the top code was reached while a lead was still present.

Top module: `phase_tune_search`

## Requirements
- R1: A start pulse restarts the search from any state on the next clock edge. It clears done and overflow. The code becomes 0 when bin_sel is 0 (linear) and 1 followed by zeros (the MSB trial) when bin_sel is 1 (binary). The code then holds until the first decision.
- R2: Decisions are made only once per eight rising edges of the synchronised sense input, counted from the start pulse. With a steady sense period of P cycles, successive linear code changes are exactly 8·P cycles apart. The code never changes except at a decision or a start.
- R3: The lead flag of a decision is the level of the synchronised reference at the synchronised sense rising edge that completes the count of eight. A 1 means the sense output leads.
- R4: In linear mode, each decision with lead 1 below the all-ones code raises the code by exactly one.
- R5: In linear mode, the first decision with lead 0 freezes the code at its present value and asserts done with overflow 0.
- R6: In linear mode, a decision with lead 1 at the all-ones code keeps the code at all-ones and asserts both overflow and done.
- R7: In binary mode, each decision keeps the trial bit on lead 1 and clears it on lead 0, then sets the next lower bit as the new trial. After CODE_W decisions, done is asserted and the code is the highest code that showed a lead, or 0 if none did.
- R8: In binary mode, if all CODE_W decisions show a lead, the code ends at all-ones with overflow asserted.
- R9: While done is high and no start arrives, the code and the flags stay constant whatever the inputs do.
- R10: During reset, code is 0 and done and overflow are 0. After reset they stay so until a start pulse.
- R11: Overflow is never high unless done is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Synchronous pulse that begins a search |
| bin_sel | input | 1 | Search order captured at start: 0 linear, 1 binary |
| ref_sq | input | 1 | Asynchronous squared reference tone |
| sns_sq | input | 1 | Asynchronous squared filter sense output |
| code | output | CODE_W | Transconductance code to the external converter |
| done | output | 1 | Search finished, result held |
| overflow | output | 1 | Top code reached while the lead persisted |

## Verification
The hardest situation to reach is the far end of a linear search. That case needs a lead on every one of the 256 codes, including the all-ones code, and each code costs eight sense periods. The bench models the filter as a code-dependent phase shift. The sense wave lags the reference by a quarter period while the code is below a threshold and by three quarters once it is not. Setting the threshold above the code range forces the overflow ending, and a threshold of exactly the top code gives the case just below it. A mid-search restart and a phase flip after done cover the hold and restart paths.

// File: rtl/pts_pkg.sv
package pts_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEARCH = 2'd1,
    ST_DONE   = 2'd2
  } tune_state_e;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_BINARY = 1'b1
  } search_order_e;

endpackage

// File: rtl/pts_sync.sv
module pts_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], din[gi]};
      end
      assign dout[gi] = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/pts_step_div.sv
module pts_step_div #(
  parameter int DIV_LOG2 = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic sns_s,
  output logic sns_rise,
  output logic step
);

  localparam logic [DIV_LOG2-1:0] CNT_LAST = '1;

  logic                sns_d;
  logic [DIV_LOG2-1:0] rise_cnt;

  assign sns_rise = sns_s & ~sns_d;
  assign step     = sns_rise && (rise_cnt == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sns_d    <= 1'b0;
      rise_cnt <= '0;
    end else begin
      sns_d <= sns_s;
      if (restart)       rise_cnt <= '0;
      else if (sns_rise) rise_cnt <= rise_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/pts_phase_flag.sv
module pts_phase_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic step,
  input  logic ref_s,
  output logic decide,
  output logic lead
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      decide <= 1'b0;
      lead   <= 1'b0;
    end else if (restart) begin
      decide <= 1'b0;
    end else begin
      decide <= step;
      if (step) lead <= ref_s;
    end
  end

endmodule

// File: rtl/pts_search_ctrl.sv
module pts_search_ctrl
  import pts_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              bin_sel,
  input  logic              decide,
  input  logic              lead,
  output logic [CODE_W-1:0] code,
  output logic              done,
  output logic              overflow,
  output logic              searching,
  output logic              bin_mode
);

  localparam logic [CODE_W-1:0] CODE_MAX = '1;
  localparam logic [CODE_W-1:0] CODE_ONE = {{(CODE_W-1){1'b0}}, 1'b1};
  localparam logic [CODE_W-1:0] CODE_MSB = CODE_ONE << (CODE_W-1);

  tune_state_e       state;
  search_order_e     order;
  logic [CODE_W-1:0] trial_bit;
  logic [CODE_W-1:0] resolved;

  function automatic logic [CODE_W-1:0] lin_next(input logic [CODE_W-1:0] c);
    return c + CODE_ONE;
  endfunction

  function automatic logic [CODE_W-1:0] bin_resolve(input logic [CODE_W-1:0] c,
                                                     input logic [CODE_W-1:0] bitmask,
                                                     input logic              keep);
    return keep ? c : (c & ~bitmask);
  endfunction

  function automatic logic [CODE_W-1:0] start_code(input logic binary);
    return binary ? CODE_MSB : '0;
  endfunction

  assign resolved  = bin_resolve(code, trial_bit, lead);
  assign searching = (state == ST_SEARCH);
  assign done      = (state == ST_DONE);
  assign bin_mode  = (order == ORD_BINARY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      order     <= ORD_LINEAR;
      code      <= '0;
      trial_bit <= '0;
      overflow  <= 1'b0;
    end else if (start) begin
      state     <= ST_SEARCH;
      order     <= bin_sel ? ORD_BINARY : ORD_LINEAR;
      code      <= start_code(bin_sel);
      trial_bit <= CODE_MSB;
      overflow  <= 1'b0;
    end else if (searching && decide) begin
      if (order == ORD_LINEAR) begin
        if (!lead) begin
          state <= ST_DONE;
        end else if (code == CODE_MAX) begin
          overflow <= 1'b1;
          state    <= ST_DONE;
        end else begin
          code <= lin_next(code);
        end
      end else begin
        if (trial_bit[0]) begin
          code     <= resolved;
          overflow <= (resolved == CODE_MAX);
          state    <= ST_DONE;
        end else begin
          code      <= resolved | (trial_bit >> 1);
          trial_bit <= trial_bit >> 1;
        end
      end
    end
  end

endmodule

// File: rtl/phase_tune_search.sv
module phase_tune_search #(
  parameter int CODE_W      = 8,
  parameter int DIV_LOG2    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              bin_sel,
  input  logic              ref_sq,
  input  logic              sns_sq,
  output logic [CODE_W-1:0] code,
  output logic              done,
  output logic              overflow
);

  logic [1:0] raw_w;
  logic [1:0] sync_w;
  logic       ref_s_w;
  logic       sns_s_w;
  logic       sns_rise_w;
  logic       step_w;
  logic       decide_w;
  logic       lead_w;
  logic       searching_w;
  logic       bin_mode_w;

  assign raw_w   = {sns_sq, ref_sq};
  assign ref_s_w = sync_w[0];
  assign sns_s_w = sync_w[1];

  pts_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (raw_w),
    .dout (sync_w)
  );

  pts_step_div #(.DIV_LOG2(DIV_LOG2)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (start),
    .sns_s   (sns_s_w),
    .sns_rise(sns_rise_w),
    .step    (step_w)
  );

  pts_phase_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(start),
    .step   (step_w),
    .ref_s  (ref_s_w),
    .decide (decide_w),
    .lead   (lead_w)
  );

  pts_search_ctrl #(.CODE_W(CODE_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .bin_sel  (bin_sel),
    .decide   (decide_w),
    .lead     (lead_w),
    .code     (code),
    .done     (done),
    .overflow (overflow),
    .searching(searching_w),
    .bin_mode (bin_mode_w)
  );

endmodule

// File: rtl/pts_checker.sv
module pts_checker #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [CODE_W-1:0] code,
  input logic              done,
  input logic              overflow,
  input logic              decide,
  input logic              lead,
  input logic              searching,
  input logic              bin_mode
);

  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  p_start_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && !overflow));

  p_code_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!decide && !start) |=> $stable(code));

  p_lin_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && searching && !bin_mode && lead && code != CODE_MAX && !start)
      |=> (code == $past(code) + 1'b1));

  p_lin_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && searching && !bin_mode && !lead && !start)
      |=> (done && !overflow && $stable(code)));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(code) && $stable(overflow)));

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> done);

endmodule

bind phase_tune_search pts_checker #(.CODE_W(CODE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .code     (code),
  .done     (done),
  .overflow (overflow),
  .decide   (decide_w),
  .lead     (lead_w),
  .searching(searching_w),
  .bin_mode (bin_mode_w)
);

// File: tb/phase_tune_search_test.sv
module phase_tune_search_test;

  localparam int CW  = 8;
  localparam int PER = 16;
  localparam int NV  = 11;
  // {binary, threshold[8:0], expected code[7:0], expected overflow}
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 9'd0,   8'd0,   1'b0},
    {1'b0, 9'd5,   8'd5,   1'b0},
    {1'b0, 9'd37,  8'd37,  1'b0},
    {1'b0, 9'd255, 8'd255, 1'b0},
    {1'b0, 9'd300, 8'd255, 1'b1},
    {1'b1, 9'd0,   8'd0,   1'b0},
    {1'b1, 9'd1,   8'd0,   1'b0},
    {1'b1, 9'd100, 8'd99,  1'b0},
    {1'b1, 9'd200, 8'd199, 1'b0},
    {1'b1, 9'd255, 8'd254, 1'b0},
    {1'b1, 9'd300, 8'd255, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          bin_sel = 1'b0;
  logic          ref_sq = 1'b0;
  logic          sns_sq = 1'b0;
  logic [CW-1:0] code;
  logic          done;
  logic          overflow;

  int tests = 0;
  int fails = 0;
  int thr   = 0;
  int cyc   = 0;

  always #4 clk = ~clk;

  phase_tune_search uut (
    .clk(clk), .rst_n(rst_n), .start(start), .bin_sel(bin_sel),
    .ref_sq(ref_sq), .sns_sq(sns_sq),
    .code(code), .done(done), .overflow(overflow)
  );

  // Plant: sense lags by a quarter period while code < thr (reads as lead), else by three quarters.
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      cyc++;
      ph = (ph + 1) % PER;
      ref_sq = (ph < PER/2);
      sns_sq = (((ph - ((int'(code) < thr) ? PER/4 : 3*PER/4) + PER) % PER) < PER/2);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic b);
    @(negedge clk);
    bin_sel = b;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 40000; i++) begin
      if (done) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int t0;
    int t1;
    logic [CW-1:0] prev;
    repeat (3) @(negedge clk);
    check("R10 reset code", int'(code), 0);
    check("R10 reset done", int'(done), 0);
    check("R10 reset overflow", int'(overflow), 0);
    rst_n = 1'b1;
    repeat (200) @(negedge clk);
    check("R10 idle code after reset", int'(code), 0);
    check("R10 idle done after reset", int'(done), 0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      logic b;
      logic eo;
      int ec;
      b  = VEC[v][18];
      thr = int'(VEC[v][17:9]);
      ec = int'(VEC[v][8:1]);
      eo = VEC[v][0];
      pulse_start(b);
      check(b ? "R1 binary start trial" : "R1 linear start code", int'(code), b ? 128 : 0);
      wait_done();
      if (b) begin
        check(eo ? "R8 binary overflow code" : "R7 binary result", int'(code), ec);
        check(eo ? "R8 binary overflow flag" : "R7 binary overflow flag", int'(overflow), int'(eo));
      end else begin
        check(eo ? "R6 linear saturated code" : "R5 linear frozen code", int'(code), ec);
        check(eo ? "R6 linear overflow flag" : "R5 linear overflow flag", int'(overflow), int'(eo));
      end
      check(eo ? "R11 done with overflow" : "R5 done", int'(done), 1);
    end

    // Lead flag meaning: ref high at sense edge counts as lead
    thr = 3;
    pulse_start(1'b0);
    wait_done();
    check("R3 lead flag stops at threshold", int'(code), 3);

    // Cadence and single-step increments
    thr = 50;
    pulse_start(1'b0);
    t0 = cyc;
    while (code == 0 && cyc - t0 < 2000) @(negedge clk);
    check("R2 first decision not before eight periods", int'((cyc - t0) >= 7*PER && (cyc - t0) <= 9*PER + 8), 1);
    t1 = cyc;
    prev = code;
    check("R4 first increment value", int'(code), 1);
    for (int k = 0; k < 4; k++) begin
      while (code == prev && cyc - t1 < 2000) @(negedge clk);
      check("R2 decision spacing", cyc - t1, 8*PER);
      check("R4 increment by one", int'(code), int'(prev) + 1);
      t1 = cyc;
      prev = code;
    end
    check("R5 done low mid-search", int'(done), 0);

    // Restart in the middle of a search
    pulse_start(1'b0);
    check("R1 restart code", int'(code), 0);
    check("R1 restart done", int'(done), 0);
    wait_done();
    check("R5 restarted search result", int'(code), 50);

    // Hold after done while the phase relationship changes
    thr = 0;
    repeat (1000) @(negedge clk);
    check("R9 code held", int'(code), 50);
    check("R9 done held", int'(done), 1);
    thr = 300;
    repeat (1000) @(negedge clk);
    check("R9 code held after flip", int'(code), 50);
    check("R9 overflow held low", int'(overflow), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule